// File: doc/BRIEF.md
# Graded-Segment Carry-Select Adder

This block adds two 32-bit operands and a carry-in and gives a 32-bit sum and a carry-out. The operands are cut into segments. The lowest segment is a plain ripple adder fed by the external carry-in. Every higher segment works out two speculative results in parallel. One assumes its incoming carry is clear and the other assumes it is set. The real carry from the segment just below then selects one of the two results, both the sum bits and the carry onward.

In the default configuration the segments grow upward as 5, 7, 9 and 11 bits, covering bits [4:0], [11:5], [20:12] and [31:21]. Each wider segment has more time to settle its speculative sums while the select carry travels up from below, so both arrive at its multiplexer at about the same time. A parameter picks an equal two-halves split (16/16) for comparison. A second parameter places a register on the sum and carry-out, and it is on by default, so results appear one clock after the operands.

Top module: `csa_adder`

## Requirements
- R1: One clock edge after operands `op_a`, `op_b` and `carry_in` are presented, `{carry_out, sum}` equals the 33-bit unsigned value op_a + op_b + carry_in, for every operand value.
- R2: A carry that ripples through all 32 bit positions (for example 0xFFFFFFFF + 0 with carry_in 1, or 0xFFFFFFFF + 1) gives sum 0 and carry_out 1.
- R3: In the graded split the segment boundaries sit at bit 5, bit 12 and bit 21. A carry out of the top bit of any segment reaches the lowest bit of the segment above, so (2^k - 1) + 1 gives exactly 2^k for k = 5, 12, 21 and 16.
- R4: Each upper segment keeps two speculative results, one for an incoming carry of 0 and one for 1. The set-carry sum is always the clear-carry sum plus one, and the set-carry copy always carries out whenever the clear-carry copy does. The carry from the segment below selects the result. Operands with op_b = ~op_a give all ones with carry_out 0 when carry_in is 0, and zero with carry_out 1 when carry_in is 1.
- R5: The lowest segment takes carry_in directly: 0 + 0 + 1 gives 1, and 0x1F + 0 + 1 gives 0x20.
- R6: The equal-halves configuration (SPLIT = SPLIT_HALVES) gives the same sum and carry-out as the graded configuration for every input.
- R7: While rst_n is low the registered sum and carry_out are 0, and each result appears exactly one clock edge after its operands.
- R8: carry_out is the selected carry of the top segment: 0x80000000 + 0x80000000 gives carry_out 1 and sum 0, and 0xFFE00000 + 0x00200000 gives carry_out 1 and sum 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | 32 | First addend |
| op_b | input | 32 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 32 | Sum bits |
| carry_out | output | 1 | Carry out of bit 31 |

## Verification
The hardest case is a carry that crosses a segment boundary in the same cycle that the top segment has to produce the final carry-out. Then every select multiplexer switches to its set-carry copy at once. The bench provokes this with all-ones operands plus one and with op_b equal to ~op_a under both carry-in values. It also uses single-boundary crossings at bits 5, 12, 21 and 16. Every result, both graded and halved, is judged one cycle later against a behavioural 33-bit addition held in the scoreboard queue.

// File: rtl/csa_pkg.sv
package csa_pkg;

   typedef enum int {
      SPLIT_GRADED = 0,
      SPLIT_HALVES = 1
   } split_e;

   function automatic int seg_count(split_e mode);
      return (mode == SPLIT_GRADED) ? 4 : 2;
   endfunction

   function automatic int seg_width(split_e mode, int idx, int total);
      if (mode == SPLIT_HALVES) return total / 2;
      case (idx)
         0:       return 5;
         1:       return 7;
         2:       return 9;
         default: return 11;
      endcase
   endfunction

   function automatic int seg_base(split_e mode, int idx, int total);
      int acc;
      acc = 0;
      for (int k = 0; k < idx; k++) acc += seg_width(mode, k, total);
      return acc;
   endfunction

   function automatic int seg_span(split_e mode, int total);
      return seg_base(mode, seg_count(mode), total);
   endfunction

endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         ci,
   output logic [W-1:0] s,
   output logic         co
);
   logic [W:0] chain;

   assign chain[0] = ci;

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic half;
      assign half       = a[i] ^ b[i];
      assign s[i]       = half ^ chain[i];
      assign chain[i+1] = (a[i] & b[i]) | (half & chain[i]);
   end

   assign co = chain[W];
endmodule

// File: rtl/csa_segment.sv
module csa_segment #(
   parameter int W        = 8,
   parameter bit IS_FIRST = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         ci,
   output logic [W-1:0] s,
   output logic         co
);
   if (W < 1) begin : g_bad_w
      $error("csa_segment: W must be at least 1");
   end

   if (IS_FIRST) begin : g_direct
      csa_ripple #(.W(W)) u_chain (
         .a(a), .b(b), .ci(ci), .s(s), .co(co)
      );
   end else begin : g_select
      localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
      logic [W-1:0] sum_lo, sum_hi;
      logic         c_lo, c_hi;

      csa_ripple #(.W(W)) u_guess0 (
         .a(a), .b(b), .ci(1'b0), .s(sum_lo), .co(c_lo)
      );
      csa_ripple #(.W(W)) u_guess1 (
         .a(a), .b(b), .ci(1'b1), .s(sum_hi), .co(c_hi)
      );

      assign s  = ci ? sum_hi : sum_lo;
      assign co = ci ? c_hi   : c_lo;

      always_comb begin
         AST_GUESS_STEP: assert (sum_hi == sum_lo + ONE); // R4
         AST_GUESS_CARRY: assert (!c_lo || c_hi); // R4
      end
   end
endmodule

// File: rtl/csa_out_stage.sv
module csa_out_stage #(
   parameter int W      = 32,
   parameter bit REG_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_sum,
   input  logic         d_co,
   output logic [W-1:0] q_sum,
   output logic         q_co
);
   if (REG_EN) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_sum <= '0;
            q_co  <= 1'b0;
         end else begin
            q_sum <= d_sum;
            q_co  <= d_co;
         end
      end
   end else begin : g_wire
      assign q_sum = d_sum;
      assign q_co  = d_co;
   end
endmodule

// File: rtl/csa_adder.sv
module csa_adder #(
   parameter int              WIDTH  = 32,
   parameter csa_pkg::split_e SPLIT  = csa_pkg::SPLIT_GRADED,
   parameter bit              OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] sum,
   output logic             carry_out
);
   import csa_pkg::*;

   localparam int NSEG = seg_count(SPLIT);
   localparam int W1   = WIDTH + 1;

   if (seg_span(SPLIT, WIDTH) != WIDTH) begin : g_bad_span
      $error("csa_adder: segment widths do not cover WIDTH");
   end
   if (SPLIT == SPLIT_HALVES && (WIDTH % 2) != 0) begin : g_bad_half
      $error("csa_adder: halves split needs an even WIDTH");
   end

   logic [NSEG:0]    seg_c;
   logic [WIDTH-1:0] raw_sum;

   assign seg_c[0] = carry_in;

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      localparam int BASE = seg_base(SPLIT, g, WIDTH);
      localparam int SW   = seg_width(SPLIT, g, WIDTH);

      csa_segment #(.W(SW), .IS_FIRST(g == 0)) u_seg (
         .a (op_a[BASE +: SW]),
         .b (op_b[BASE +: SW]),
         .ci(seg_c[g]),
         .s (raw_sum[BASE +: SW]),
         .co(seg_c[g+1])
      );
   end

   csa_out_stage #(.W(WIDTH), .REG_EN(OUT_REG)) u_out (
      .clk  (clk),
      .rst_n(rst_n),
      .d_sum(raw_sum),
      .d_co (seg_c[NSEG]),
      .q_sum(sum),
      .q_co (carry_out)
   );

   if (OUT_REG) begin : g_chk_reg
      AST_EXACT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> {carry_out, sum} ==
            ($past({1'b0, op_a}) + $past({1'b0, op_b}) + {{WIDTH{1'b0}}, $past(carry_in)})); // R1
      AST_FULL_RIPPLE: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(&(op_a ^ op_b)) && $past(carry_in)) |->
            (carry_out && sum == '0)); // R2
      AST_RESET_CLEAR: assert property (@(posedge clk)
         !rst_n |-> (sum == '0 && !carry_out)); // R7
   end else begin : g_chk_comb
      logic [W1-1:0] ref_val;
      assign ref_val = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
      always_comb begin
         AST_EXACT_SUM_C: assert ({carry_out, sum} == ref_val); // R1
      end
   end
endmodule

// File: tb/csa_adder_bench.sv
module csa_adder_bench;
   localparam int W = 32;

   typedef struct {
      logic [W-1:0] e_sum;
      logic         e_co;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] op_a = '0, op_b = '0;
   logic         carry_in = 1'b0;
   logic [W-1:0] sum_g, sum_h;
   logic         co_g, co_h;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   exp_t sb[$];

   always #5 clk = ~clk;

   csa_adder #(.SPLIT(csa_pkg::SPLIT_GRADED)) u_csa_adder (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
      .carry_in(carry_in), .sum(sum_g), .carry_out(co_g)
   );

   csa_adder #(.SPLIT(csa_pkg::SPLIT_HALVES)) u_csa_adder_halves (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
      .carry_in(carry_in), .sum(sum_h), .carry_out(co_h)
   );

   task automatic judge(string tag, logic [W:0] act, logic [W:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: applies operands at the falling edge and queues the reference
   task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic ci, string tag);
      logic [W:0] r;
      @(negedge clk);
      op_a = a;
      op_b = b;
      carry_in = ci;
      r = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
      sb.push_back('{e_sum: r[W-1:0], e_co: r[W], tag: tag});
   endtask

   // monitor: the register captures at the rising edge, sample 1 ns later
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            judge(it.tag, {co_g, sum_g}, {it.e_co, it.e_sum});
            judge({"R6 halves ", it.tag}, {co_h, sum_h}, {it.e_co, it.e_sum});
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      op_a = 32'hFFFF_FFFF;
      op_b = 32'h0000_0001;
      repeat (3) @(posedge clk);
      #1;
      judge("R7 reset graded", {co_g, sum_g}, '0);
      judge("R7 reset halves", {co_h, sum_h}, '0);
      @(negedge clk);
      rst_n = 1'b1;

      // R7: first result one edge after its operands
      drive(32'h0000_0003, 32'h0000_0004, 1'b0, "R7 latency");

      // R2: carry through every bit
      drive(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R2 ones+cin");
      drive(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R2 ones+1");

      // R3: single-boundary crossings
      drive(32'h0000_001F, 32'h0000_0001, 1'b0, "R3 bit5");
      drive(32'h0000_0FFF, 32'h0000_0001, 1'b0, "R3 bit12");
      drive(32'h001F_FFFF, 32'h0000_0001, 1'b0, "R3 bit21");
      drive(32'h0000_FFFF, 32'h0000_0001, 1'b0, "R3 bit16");
      drive(32'h0000_0FE0, 32'h0000_0020, 1'b0, "R3 seg1 to seg2");
      drive(32'h001F_F000, 32'h0000_1000, 1'b0, "R3 seg2 to seg3");

      // R4: select lines switch in every segment at once
      drive(32'h1234_5678, ~32'h1234_5678, 1'b0, "R4 complement cin0");
      drive(32'h1234_5678, ~32'h1234_5678, 1'b1, "R4 complement cin1");
      drive(32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b1, "R4 alternating");

      // R5: lowest segment uses carry_in directly
      drive(32'h0000_0000, 32'h0000_0000, 1'b1, "R5 zero+cin");
      drive(32'h0000_001F, 32'h0000_0000, 1'b1, "R5 low seg+cin");

      // R8: carry-out from top segment
      drive(32'h8000_0000, 32'h8000_0000, 1'b0, "R8 msb pair");
      drive(32'hFFE0_0000, 32'h0020_0000, 1'b0, "R8 top seg only");

      // R1: random operands
      for (int n = 0; n < 300; n++) begin
         drive($urandom, $urandom, 1'($urandom), "R1 random");
      end

      while (sb.size() > 0) @(posedge clk);
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule